// File: doc/BRIEF.md
# Three-Bank Event Interrupt Aggregator

The block gathers up to 96 hardware event sources into three 32-bit pending banks and folds them onto three level interrupt lines for a CPU interrupt controller. A source reports an event as a 7-bit code with a one-cycle strobe. The upper two bits of the code pick the bank and the lower five bits pick the bit within it. A pending bit stays set until software writes a one to it.

Each interrupt line has its own group of three 32-bit enable masks, one mask for each pending bank. Line 0 (group A) carries the highest level, line 1 (group B) the middle level and line 2 (group C) the lowest. A line is high while any bank holds a pending bit whose enable bit is set in that line's mask for the same bank. It drops only when no such bit remains in any of the three banks.

Software reaches the pending and mask registers through a plain register port. A write takes effect at the clock edge, and read data is combinational from the address. The event input is a bare strobe and is never stalled, so it has no ready signal and no back-pressure. Priority arbitration between the lines belongs to the interrupt controller.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset, all pending and mask registers read zero and all three lines are low.
- R2: When `evt_valid` is high at a clock edge, code bits 6:5 pick bank 0..2 and bits 4:0 pick the bit, and that pending bit is set after the edge. No other pending bit changes.
- R3: An event whose bank field is 3 changes no pending bit.
- R4: A pending bit stays set across any number of idle cycles until software clears it.
- R5: A write to a pending register clears exactly the bits written as one and leaves the rest unchanged.
- R6: If an event sets a bit and a write clears the same bit at the same edge, the bit ends up set.
- R7: Register address: `reg_addr[3:2]` selects 0 = pending, 1 = mask A, 2 = mask B, 3 = mask C, and `reg_addr[1:0]` selects bank 0..2. Masks read back what was written. Bank index 3 reads zero and a write to it is ignored.
- R8: `irq_lines[g]` (g = 0 for A, 1 for B, 2 for C) is high exactly when some bank b has (pending[b] AND mask[g][b]) nonzero. It reflects the register state from the cycle after the edge that changed that state.
- R9: A mask write alone, with no event, raises or drops a line on the next cycle.
- R10: Clearing one enabled pending bit leaves the line high while another enabled pending bit remains in any bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | One-cycle event strobe |
| evt_code | input | 7 | Event code: bank in [6:5], bit in [4:0] |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register select: kind in [3:2], bank in [1:0] |
| reg_wdata | input | 32 | Write data (ones clear for pending, value for masks) |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_lines | output | 3 | Level interrupt lines A, B, C |

## Verification
The bench sweeps all 128 event codes. A wrong bank decode would land a bit in the wrong register, and a design that accepted bank field 3 would alias into a real bank. It races a set against a clear on the same bit, where a clear-wins design would lose the event. It changes masks with no event present, so a design that only evaluated lines on event arrival would leave a line stale. It keeps an enabled bit pending in one bank while it clears another, so a design that dropped the line on any clear would lose an interrupt. Every line is also checked against a bench model after every step of a sweep over each group and bank pairing.

// File: rtl/eia_pkg.sv
package eia_pkg;
  // register kind codes in the upper address field; mask kinds are group + 1
  localparam int KIND_PENDING = 0;
  localparam int KIND_MASK_BASE = 1;

  function automatic int ceil_log2(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/eia_evt_decode.sv
module eia_evt_decode #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int BSEL_W    = 2,
  parameter int IDX_W     = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          evt_valid,
  input  logic [BSEL_W+IDX_W-1:0]       evt_code,
  output logic [NUM_BANKS*BANK_W-1:0]   set_vec
);
  logic [BSEL_W-1:0] bank_sel;
  logic [IDX_W-1:0]  bit_sel;

  assign bank_sel = evt_code[BSEL_W+IDX_W-1 -: BSEL_W];
  assign bit_sel  = evt_code[IDX_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      set_vec[b*BANK_W +: BANK_W] = '0;
      if (evt_valid && (bank_sel == BSEL_W'(b)))
        set_vec[b*BANK_W + int'(bit_sel)] = 1'b1;
    end
  end

  AST_SET_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_vec)); // R2
  AST_NO_SET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |-> (set_vec == '0)); // R3
endmodule

// File: rtl/eia_pend_bank.sv
module eia_pend_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] set_v,
  input  logic [BANK_W-1:0] clr_v,
  output logic [BANK_W-1:0] pend_q
);
  logic [BANK_W-1:0] pend_d;

  // set is applied after clear so a same-edge set survives
  assign pend_d = (pend_q & ~clr_v) | set_v;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  AST_ONLY_CLEARED_DROP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_v)) == '0)); // R4
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(clr_v) & ~$past(set_v)) == '0)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(set_v)) == $past(set_v))); // R6
endmodule

// File: rtl/eia_mask_reg.sv
module eia_mask_reg #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '0;
    else if (we) mask_q <= wdata;
  end

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mask_q)); // R7
endmodule

// File: rtl/eia_line_combine.sv
module eia_line_combine #(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32
) (
  input  logic [NUM_BANKS*BANK_W-1:0] pend_flat,
  input  logic [NUM_BANKS*BANK_W-1:0] mask_flat,
  output logic                        line
);
  logic [NUM_BANKS-1:0] bank_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit[b] = |(pend_flat[b*BANK_W +: BANK_W] & mask_flat[b*BANK_W +: BANK_W]);
  end

  assign line = |bank_hit;
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg #(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_W     = 32,
  parameter int NUM_GROUPS = 3,
  localparam int IDX_W     = eia_pkg::ceil_log2(BANK_W),
  localparam int BSEL_W    = eia_pkg::ceil_log2(NUM_BANKS),
  localparam int CODE_W    = BSEL_W + IDX_W,
  localparam int KIND_W    = eia_pkg::ceil_log2(NUM_GROUPS + 1),
  localparam int ADDR_W    = KIND_W + BSEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  evt_valid,
  input  logic [CODE_W-1:0]     evt_code,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [BANK_W-1:0]     reg_wdata,
  output logic [BANK_W-1:0]     reg_rdata,
  output logic [NUM_GROUPS-1:0] irq_lines
);
  localparam int FLAT_W = NUM_BANKS * BANK_W;

  logic [KIND_W-1:0] acc_kind;
  logic [BSEL_W-1:0] acc_bank;
  logic [FLAT_W-1:0] set_vec;
  logic [FLAT_W-1:0] pend_flat;
  logic [FLAT_W-1:0] mask_flat [NUM_GROUPS];

  assign acc_kind = reg_addr[ADDR_W-1 -: KIND_W];
  assign acc_bank = reg_addr[BSEL_W-1:0];

  eia_evt_decode #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BSEL_W(BSEL_W), .IDX_W(IDX_W)
  ) u_decode (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code), .set_vec(set_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pend
    logic [BANK_W-1:0] clr_v;
    assign clr_v = (reg_we && acc_kind == KIND_W'(eia_pkg::KIND_PENDING)
                    && acc_bank == BSEL_W'(b)) ? reg_wdata : '0;
    eia_pend_bank #(.BANK_W(BANK_W)) u_pend (
      .clk(clk), .rst(rst),
      .set_v(set_vec[b*BANK_W +: BANK_W]),
      .clr_v(clr_v),
      .pend_q(pend_flat[b*BANK_W +: BANK_W])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_msk
      logic mwe;
      assign mwe = reg_we && acc_kind == KIND_W'(eia_pkg::KIND_MASK_BASE + g)
                   && acc_bank == BSEL_W'(b);
      eia_mask_reg #(.BANK_W(BANK_W)) u_mask (
        .clk(clk), .rst(rst), .we(mwe), .wdata(reg_wdata),
        .mask_q(mask_flat[g][b*BANK_W +: BANK_W])
      );
    end
    eia_line_combine #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_line (
      .pend_flat(pend_flat), .mask_flat(mask_flat[g]), .line(irq_lines[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (acc_bank == BSEL_W'(b)) begin
        if (acc_kind == KIND_W'(eia_pkg::KIND_PENDING))
          reg_rdata = pend_flat[b*BANK_W +: BANK_W];
        for (int g = 0; g < NUM_GROUPS; g++)
          if (acc_kind == KIND_W'(eia_pkg::KIND_MASK_BASE + g))
            reg_rdata = mask_flat[g][b*BANK_W +: BANK_W];
      end
    end
  end

  AST_BAD_BANK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (int'(evt_code[CODE_W-1 -: BSEL_W]) >= NUM_BANKS) && !reg_we)
    |=> $stable(pend_flat)); // R3
  AST_LINES_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!evt_valid && !reg_we) |=> $stable(irq_lines)); // R8
  AST_NO_LINE_WITHOUT_PEND: assert property (@(posedge clk) disable iff (rst)
    (pend_flat == '0) |-> (irq_lines == '0)); // R8
endmodule

// File: tb/sim_evt_irq_agg.sv
`timescale 1ns/1ps
module sim_evt_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [6:0]  evt_code = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_lines;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] mp [3];
  logic [31:0] mm [3][3];

  always #4 clk = ~clk;

  evt_irq_agg u0 (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_lines(irq_lines)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock step starting and ending at a falling edge; model updated per requirements
  task automatic step(input bit ev, input logic [6:0] code, input bit we,
                      input logic [3:0] addr, input logic [31:0] data);
    logic [31:0] setw [3];
    evt_valid = ev; evt_code = code; reg_we = we; reg_addr = addr; reg_wdata = data;
    @(posedge clk);
    for (int b = 0; b < 3; b++) setw[b] = '0;
    if (ev && code[6:5] < 2'd3) setw[code[6:5]][code[4:0]] = 1'b1;
    if (we && addr[1:0] < 2'd3) begin
      if (addr[3:2] == 2'd0) mp[addr[1:0]] &= ~data;
      else mm[addr[3:2]-1][addr[1:0]] = data;
    end
    for (int b = 0; b < 3; b++) mp[b] |= setw[b];
    @(negedge clk);
    evt_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] addr, output logic [31:0] v);
    reg_addr = addr; reg_we = 1'b0;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [2:0] exp_irq();
    logic [2:0] r;
    r = '0;
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < 3; b++)
        if ((mp[b] & mm[g][b]) != 0) r[g] = 1'b1;
    return r;
  endfunction

  task automatic chk_irq(input string tag);
    logic [2:0] e;
    e = exp_irq();
    chk(irq_lines == e, tag, {29'd0, irq_lines}, {29'd0, e});
  endtask

  task automatic chk_pend_all(input string tag);
    logic [31:0] v;
    for (int b = 0; b < 3; b++) begin
      rd(4'(b), v);
      chk(v == mp[b], tag, v, mp[b]);
    end
  endtask

  task automatic clear_all();
    for (int b = 0; b < 3; b++) step(0, '0, 1, 4'(b), 32'hFFFF_FFFF);
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < 3; b++) step(0, '0, 1, 4'(((g + 1) << 2) | b), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int b = 0; b < 3; b++) begin
      mp[b] = '0;
      for (int g = 0; g < 3; g++) mm[g][b] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk(irq_lines == 3'b000, "R1 lines after reset", {29'd0, irq_lines}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk(v == 32'd0, "R1 register after reset", v, 32'd0);
    end

    // R7: mask write / read back, bank index 3 ignored
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < 4; b++)
        step(0, '0, 1, 4'(((g + 1) << 2) | b), 32'hA5C3_0F1E ^ (32'h0101_1011 * (g * 4 + b + 1)));
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < 4; b++) begin
        rd(4'(((g + 1) << 2) | b), v);
        if (b < 3) chk(v == mm[g][b], "R7 mask readback", v, mm[g][b]);
        else       chk(v == 32'd0, "R7 bank 3 reads zero", v, 32'd0);
      end
    step(0, '0, 1, 4'd3, 32'hFFFF_FFFF);
    chk_pend_all("R7 pending bank 3 write ignored");
    clear_all();

    // R2 / R3 / R5: sweep every event code
    for (int c = 0; c < 128; c++) begin
      step(1, 7'(c), 0, '0, '0);
      chk_pend_all((c >= 96) ? "R3 bank field 3 ignored" : "R2 event decode");
      if (c < 96) begin
        step(0, '0, 1, 4'(c >> 5), 32'(1) << (c % 32));
        chk_pend_all("R5 write-one clear of swept bit");
      end
    end

    // R4: sticky across idle cycles
    step(1, 7'd45, 0, '0, '0);
    for (int i = 0; i < 6; i++) step(0, '0, 0, '0, '0);
    chk_pend_all("R4 pending held while idle");

    // R5: clear one bit, keep another
    step(1, 7'd35, 0, '0, '0);
    step(1, 7'd39, 0, '0, '0);
    step(0, '0, 1, 4'd1, 32'h0000_0008);
    rd(4'd1, v);
    chk(v == 32'h0000_2080, "R5 partial clear", v, 32'h0000_2080);
    chk_pend_all("R5 model compare");

    // R6: set and clear same bit same edge
    step(1, 7'd2, 0, '0, '0);
    step(1, 7'd4, 0, '0, '0);
    step(1, 7'd2, 1, 4'd0, 32'h0000_0014);
    rd(4'd0, v);
    chk(v == 32'h0000_0004, "R6 set wins over clear", v, 32'h0000_0004);
    clear_all();

    // R8: every group / bank pairing
    for (int g = 0; g < 3; g++)
      for (int b = 0; b < 3; b++) begin
        step(0, '0, 1, 4'(((g + 1) << 2) | b), 32'h0000_0200 | (32'(1) << (b + g)));
        chk_irq("R8 mask only, no pending");
        step(1, 7'((b << 5) | 9), 0, '0, '0);
        chk_irq("R8 enabled event raises line");
        step(1, 7'((((b + 1) % 3) << 5) | 17), 0, '0, '0);
        chk_irq("R8 other bank event");
        step(0, '0, 1, 4'(b), 32'h0000_0200);
        chk_irq("R8 line after clear");
        clear_all();
        chk_irq("R8 line after full clear");
      end

    // R9: mask change alone moves the line
    step(1, 7'd70, 0, '0, '0);
    chk(irq_lines == 3'b000, "R9 pending but masked", {29'd0, irq_lines}, 32'd0);
    step(0, '0, 1, 4'b1110, 32'h0000_0040);
    chk(irq_lines == 3'b100, "R9 mask write raises C", {29'd0, irq_lines}, 32'd4);
    step(0, '0, 1, 4'b1110, 32'h0000_0000);
    chk(irq_lines == 3'b000, "R9 mask write drops C", {29'd0, irq_lines}, 32'd0);
    clear_all();

    // R10: another bank keeps the line up
    step(0, '0, 1, 4'b0100, 32'h0000_0001);
    step(0, '0, 1, 4'b0110, 32'h8000_0000);
    step(1, 7'd0, 0, '0, '0);
    step(1, 7'd95, 0, '0, '0);
    chk(irq_lines == 3'b001, "R10 A high with two sources", {29'd0, irq_lines}, 32'd1);
    step(0, '0, 1, 4'd0, 32'h0000_0001);
    chk(irq_lines == 3'b001, "R10 A stays high after one clear", {29'd0, irq_lines}, 32'd1);
    step(0, '0, 1, 4'd2, 32'h8000_0000);
    chk(irq_lines == 3'b000, "R10 A drops when none remain", {29'd0, irq_lines}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule